// File: doc/BRIEF.md
# Repetition-Counting Shift-Clock Timer

This block is a 16-bit up-counting timer that generates the shift clock and a data-fetch strobe for a serial pixel stream. The count climbs from zero to a programmable period limit and then wraps. One compare channel turns the count into a PWM shift clock. That clock is low in the early part of each period and high from its compare point until the wrap. A second compare channel raises a one-cycle request strobe. Software places that strobe earlier in the period than the rising clock edge, so each new data word is ready before the clock latches it.

A repetition counter sets how many periods make up one burst. Each wrap with the repetition counter above zero only decrements it. Only a wrap with the repetition counter at zero produces an update event. The update event copies the period, compare and repetition preloads into the active copies and raises a sticky interrupt flag. In one-pulse mode the update event also stops the timer in hardware, so a burst is exactly (repetition + 1) clock periods with no stray pulses, and the timer waits there for the next start.

Software writes its settings through a small register port. Writes always land in preload registers. A start command clears the count, copies in every preload and sets the timer running. A stop command halts it at once.

Top module: `reptmr`

## Requirements
- R1: While running, the count advances by one per cycle from 0 up to the active period value P and then returns to 0, so one clock period lasts P+1 cycles.
- R2: The shift clock is low while the count is below the active clock compare C and high from the cycle the count equals C through the cycle it equals P; when 0 < C <= P it rises exactly once per period.
- R3: The data request is high for exactly one cycle per period, the cycle in which the count equals the active request compare, and never for two cycles in a row.
- R4: A wrap with the repetition counter nonzero decrements it and produces no update, so a repetition value R yields (R+1) periods per update; R = 255 gives 256 periods.
- R5: An update event occurs only on a wrap with the repetition counter at zero; it sets the interrupt flag in that cycle's edge and not earlier.
- R6: On an update event the active period, both compares and the repetition counter are reloaded from their preload registers, and following periods use the new values.
- R7: With one-pulse mode on, the running flag drops at the update event and stays low, with no further clock or request activity, until the next start.
- R8: A start command sets the running flag, clears the count to 0 and loads the active copies from the preloads; start wins over stop in the same cycle.
- R9: While not running, the shift clock and the data request are both low.
- R10: The interrupt flag stays set until a write to select 5 with data bit 0 set; a new update event in the same cycle takes priority over the clear.
- R11: Register writes go to preload storage only: select 0 period, 1 clock compare, 2 request compare, 3 repetition (low 8 bits), 4 control (bit 0 = one-pulse mode); writes while running leave the current burst unchanged.
- R12: A stop command clears the running flag on the next clock edge and the outputs go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrSel | input | 3 | Register select (0 period, 1 clock compare, 2 request compare, 3 repetition, 4 control, 5 interrupt clear) |
| wrData | input | 16 | Write data |
| startCmd | input | 1 | Start: clear count, load active copies, run |
| stopCmd | input | 1 | Stop: halt the counter |
| shiftClk | output | 1 | PWM shift clock |
| dataReq | output | 1 | One-cycle data request strobe |
| updIrq | output | 1 | Sticky update interrupt flag |
| running | output | 1 | Timer running flag |

## Verification
The bench builds the block with its default widths: a 16-bit count and an 8-bit repetition counter. With an 8-bit repetition counter, a burst of 256 periods fits in about a thousand cycles, so the full-range repetition case is checked cycle by cycle. Short periods of 4 and 8 cycles let the bench see the timing of a continuous-mode update and its reload. They also cover a preload change made in the middle of a run and a stop in the middle of a period, each within a few dozen cycles.

// File: rtl/reptmr_pkg.sv
package reptmr_pkg;

  typedef enum logic [2:0] {
    SEL_PERIOD = 3'd0,
    SEL_CMPCLK = 3'd1,
    SEL_CMPREQ = 3'd2,
    SEL_REP    = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_IRQCLR = 3'd5
  } regSel_e;

  typedef struct packed {
    logic reload;  // start: clear count, copy preloads
    logic active;  // timer running, advance count
    logic update;  // update event this cycle
  } ctlStrb_t;

endpackage

// File: rtl/reptmr_dp.sv
module reptmr_dp
  import reptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  ctlStrb_t         strb,
  output logic             wrapHit,
  output logic             repZero,
  output logic             shiftClk,
  output logic             dataReq
);

  logic [CNT_W-1:0] prePeriod, preCmpClk, preCmpReq;
  logic [REP_W-1:0] preRep;
  logic [CNT_W-1:0] shPeriod, shCmpClk, shCmpReq;
  logic [CNT_W-1:0] cnt;
  logic [REP_W-1:0] repCnt;

  // preload registers, written at any time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prePeriod <= '0;
      preCmpClk <= '0;
      preCmpReq <= '0;
      preRep    <= '0;
    end else if (wrEn) begin
      case (wrSel)
        SEL_PERIOD: prePeriod <= wrData;
        SEL_CMPCLK: preCmpClk <= wrData;
        SEL_CMPREQ: preCmpReq <= wrData;
        SEL_REP:    preRep    <= wrData[REP_W-1:0];
        default: ;
      endcase
    end
  end

  assign wrapHit = (cnt == shPeriod);
  assign repZero = (repCnt == '0);

  // counter, repetition counter and active copies
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      repCnt   <= '0;
      shPeriod <= '0;
      shCmpClk <= '0;
      shCmpReq <= '0;
    end else if (strb.reload) begin
      cnt      <= '0;
      repCnt   <= preRep;
      shPeriod <= prePeriod;
      shCmpClk <= preCmpClk;
      shCmpReq <= preCmpReq;
    end else if (strb.active) begin
      if (wrapHit) begin
        cnt <= '0;
        if (strb.update) begin
          repCnt   <= preRep;
          shPeriod <= prePeriod;
          shCmpClk <= preCmpClk;
          shCmpReq <= preCmpReq;
        end else begin
          repCnt <= repCnt - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign shiftClk = strb.active && (cnt >= shCmpClk);
  assign dataReq  = strb.active && (cnt == shCmpReq);

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && wrapHit && !strb.reload) |=> (cnt == '0));

  // R4
  rep_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && wrapHit && !repZero && !strb.reload)
      |=> (repCnt == $past(repCnt) - 1'b1));

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.reload && !strb.update)
      |=> ($stable(shPeriod) && $stable(shCmpClk) && $stable(shCmpReq)));

endmodule

// File: rtl/reptmr_ctl.sv
module reptmr_ctl
  import reptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic       wrBit0,
  input  logic       startCmd,
  input  logic       stopCmd,
  input  logic       wrapHit,
  input  logic       repZero,
  output ctlStrb_t   strb,
  output logic       running,
  output logic       updIrq
);

  logic onePulse;
  logic updEvt;
  logic irqClr;

  assign updEvt = running && wrapHit && repZero && !startCmd;
  assign irqClr = wrEn && (wrSel == SEL_IRQCLR) && wrBit0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onePulse <= 1'b0;
    end else if (wrEn && (wrSel == SEL_CTRL)) begin
      onePulse <= wrBit0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (startCmd) begin
      running <= 1'b1;
    end else if (stopCmd) begin
      running <= 1'b0;
    end else if (updEvt && onePulse) begin
      running <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updIrq <= 1'b0;
    end else if (updEvt) begin
      updIrq <= 1'b1;
    end else if (irqClr) begin
      updIrq <= 1'b0;
    end
  end

  always_comb begin
    strb.reload = startCmd;
    strb.active = running;
    strb.update = updEvt;
  end

  // R7
  onepulse_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updEvt && onePulse) |=> !running);

  // R5
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> updIrq);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updIrq && !irqClr) |=> updIrq);

  // R8
  start_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> running);

  // R12
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopCmd && !startCmd) |=> !running);

endmodule

// File: rtl/reptmr.sv
module reptmr
  import reptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic             startCmd,
  input  logic             stopCmd,
  output logic             shiftClk,
  output logic             dataReq,
  output logic             updIrq,
  output logic             running
);

  ctlStrb_t strb;
  logic     wrapHit;
  logic     repZero;

  reptmr_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrBit0   (wrData[0]),
    .startCmd (startCmd),
    .stopCmd  (stopCmd),
    .wrapHit  (wrapHit),
    .repZero  (repZero),
    .strb     (strb),
    .running  (running),
    .updIrq   (updIrq)
  );

  reptmr_dp #(
    .CNT_W (CNT_W),
    .REP_W (REP_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .strb     (strb),
    .wrapHit  (wrapHit),
    .repZero  (repZero),
    .shiftClk (shiftClk),
    .dataReq  (dataReq)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !$past(startCmd)) |-> (!shiftClk && !dataReq));

endmodule

// File: tb/reptmr_tb.sv
`timescale 1ns/1ps
module reptmr_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        startCmd = 1'b0;
  logic        stopCmd = 1'b0;
  logic        shiftClk, dataReq, updIrq, running;

  always #2.5 clk = ~clk;

  reptmr u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .startCmd(startCmd), .stopCmd(stopCmd),
    .shiftClk(shiftClk), .dataReq(dataReq), .updIrq(updIrq), .running(running)
  );

  typedef struct {
    int ticks;
    int highs;
    int rises;
    int reqs;
  } exp_t;

  exp_t sbq[$];
  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t burst(input int p, input int r, input int c1, input int c4);
    exp_t e;
    e.ticks = (r + 1) * (p + 1);
    e.highs = (c1 <= p) ? (r + 1) * (p + 1 - c1) : 0;
    e.rises = (c1 > 0 && c1 <= p) ? r + 1 : 0;
    e.reqs  = (c4 <= p) ? r + 1 : 0;
    return e;
  endfunction

  // driver helpers, each called at a falling edge
  task automatic wr(input logic [2:0] sel, input int data);
    wrEn = 1'b1; wrSel = sel; wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic startRun();
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
  endtask

  task automatic stopRun();
    stopCmd = 1'b1;
    @(negedge clk);
    stopCmd = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (running);
  endtask

  task automatic setup(input int p, input int c1, input int c4, input int r);
    wr(3'd0, p);
    wr(3'd1, c1);
    wr(3'd2, c4);
    wr(3'd3, r);
  endtask

  // monitor: measures each burst and compares with the scoreboard
  int mTicks = 0, mHighs = 0, mRises = 0, mReqs = 0;
  bit prevRun = 0, prevClk = 0, prevReq = 0;
  initial begin
    @(posedge rstN);
    forever begin
      @(negedge clk);
      if (running) begin
        mTicks++;
        if (shiftClk) mHighs++;
        if (shiftClk && !prevClk) mRises++;
        if (dataReq) begin
          mReqs++;
          chk(!prevReq, "R3 one-cycle request", 2, 1);
        end
      end else begin
        chk(!shiftClk && !dataReq, "R9 idle outputs", int'(shiftClk) + int'(dataReq), 0);
      end
      if (prevRun && !running) begin
        if (sbq.size() == 0) begin
          chk(0, "R7 unexpected burst end", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(mTicks == e.ticks, "R1 R4 burst length", mTicks, e.ticks);
          chk(mHighs == e.highs, "R2 clock high cycles", mHighs, e.highs);
          chk(mRises == e.rises, "R2 clock rises", mRises, e.rises);
          chk(mReqs == e.reqs, "R3 request count", mReqs, e.reqs);
        end
        mTicks = 0; mHighs = 0; mRises = 0; mReqs = 0;
      end
      prevRun = running;
      prevClk = running && shiftClk;
      prevReq = running && dataReq;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk(!running, "R8 reset running", running, 0);
    chk(!updIrq, "R10 reset irq", updIrq, 0);
    chk(!shiftClk && !dataReq, "R9 reset outputs", int'(shiftClk) + int'(dataReq), 0);

    // one-pulse burst, 4 periods of 16 cycles
    wr(3'd4, 1);
    setup(15, 8, 3, 3);
    sbq.push_back(burst(15, 3, 8, 3));
    startRun();
    chk(running, "R8 start sets running", running, 1);
    waitIdle();
    chk(updIrq, "R5 irq after burst", updIrq, 1);
    chk(!running, "R7 halted", running, 0);
    repeat (20) @(negedge clk);
    chk(!running, "R7 stays halted", running, 0);
    chk(updIrq, "R10 irq sticky", updIrq, 1);
    wr(3'd5, 0);
    chk(updIrq, "R10 clear needs bit0", updIrq, 1);
    wr(3'd5, 1);
    chk(!updIrq, "R10 irq cleared", updIrq, 0);

    // full-range repetition: 256 periods
    setup(3, 2, 1, 255);
    sbq.push_back(burst(3, 255, 2, 1));
    startRun();
    waitIdle();
    chk(updIrq, "R4 irq after 256 periods", updIrq, 1);
    wr(3'd5, 1);

    // preload writes during a run leave the burst unchanged
    setup(7, 4, 2, 1);
    sbq.push_back(burst(7, 1, 4, 2));
    startRun();
    setup(3, 2, 1, 0);
    waitIdle();
    wr(3'd5, 1);
    sbq.push_back(burst(3, 0, 2, 1));
    startRun();
    waitIdle();
    chk(updIrq, "R11 new values after start", updIrq, 1);
    wr(3'd5, 1);

    // stop in mid-period
    setup(15, 8, 3, 3);
    begin
      exp_t e;
      e.ticks = 20; e.highs = 8; e.rises = 1; e.reqs = 2;
      sbq.push_back(e);
    end
    startRun();
    repeat (19) @(negedge clk);
    chk(running, "R12 running before stop", running, 1);
    stopRun();
    chk(!running, "R12 stopped", running, 0);
    chk(!updIrq, "R5 no update on stop", updIrq, 0);

    // continuous mode, update timing and reload
    wr(3'd4, 0);
    setup(3, 2, 1, 1);
    begin
      exp_t e;
      e.ticks = 25; e.highs = 16; e.rises = 4; e.reqs = 4;
      sbq.push_back(e);
    end
    startRun();
    wr(3'd0, 7);
    repeat (6) @(negedge clk);
    chk(!updIrq, "R5 no irq before last wrap", updIrq, 0);
    @(negedge clk);
    chk(updIrq, "R5 irq on zero-rep wrap", updIrq, 1);
    chk(running, "R7 continuous keeps running", running, 1);
    wr(3'd5, 1);
    chk(!updIrq, "R10 cleared while running", updIrq, 0);
    repeat (14) @(negedge clk);
    chk(!updIrq, "R6 reloaded period longer", updIrq, 0);
    @(negedge clk);
    chk(updIrq, "R6 update after reloaded periods", updIrq, 1);
    stopRun();
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R7 all bursts seen", sbq.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule